// File: doc/BRIEF.md
# Wake Event Control Register

This block is one 8-bit control and status register inside a network controller. It decides which kinds of incoming traffic or cable activity may wake the sleeping host, records which of them has done so, and drives an external wake pin together with an interrupt request. Software reaches it through a plain register port: a byte address, a write strobe, a read strobe and 8-bit data in each direction. It answers only at its own byte address.

Three event sources feed it: a one-cycle pulse from the wake-packet matcher, a one-cycle pulse from the magic-packet matcher, and the link status level, which is synchronized inside the block and turned into a change pulse on every connect and every disconnect. Each event is recorded only when its own enable bit is set and the block is armed. The block is armed either when the power management enable input is high and the power state is not full-on (D0), or when the wake-on-LAN override bit is set. That override bit is preset at reset from a nonvolatile default. The recorded flags stay set until software reads the register. Any set flag drives the wake pin to its asserted level, which software chooses, and raises the interrupt request.

Top module: `wake_ctl_reg`

## Requirements
- R1: While reset is active, and immediately after it, a read returns 0x00 in bits 6..0. Bit 7 holds the value of the nonvolatile wake-on-LAN default input as sampled during reset.
- R2: The register responds only at byte address 0x45. A write to any other address changes nothing. A read of any other address returns 0x00.
- R3: Bits 0, 1, 2, 3 and 7 are writable and read back what was written. Writes to bits 4, 5 and 6 are ignored.
- R4: The enable bits gate the status flags. Bit 0 gates the wake-packet flag in bit 4, bit 1 gates the magic-packet flag in bit 5, and bit 2 gates the link-change flag in bit 6. A flag never sets while its enable is 0.
- R5: With bit 7 clear, an enabled event sets its flag only when the PME enable input is 1 and the 2-bit power state input is not 2'b00 (D0).
- R6: With bit 7 set, an enabled event sets its flag whatever the PME enable input and the power state are.
- R7: A rising edge on the link status input records a link event, and so does a falling edge. The flag becomes visible three clock edges after the input changes.
- R8: A read at 0x45 returns the current flags. All three flags are cleared at the clock edge that ends the read cycle. Flags that are not read stay set.
- R9: An event that arrives in the same cycle as a clearing read is kept. It shows as set on the next read.
- R10: Bit 3 sets the asserted level of the wake pin: 1 means high, 0 means low. The pin is asserted, and the interrupt request is high, exactly while any flag is set. Otherwise the pin sits at the opposite level and the interrupt request is low.
- R11: When no read is being made, the read data bus is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wol_default_i | input | 1 | Nonvolatile wake-on-LAN default, loaded into bit 7 during reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the read strobe |
| wpkt_hit_i | input | 1 | One-cycle pulse: wake packet matched |
| mpkt_hit_i | input | 1 | One-cycle pulse: magic packet matched |
| link_up_i | input | 1 | Link status level, asynchronous |
| pme_en_i | input | 1 | Power management event enable |
| pwr_state_i | input | 2 | Current power state, 2'b00 is D0 |
| wake_pin_o | output | 1 | External wake pin, with programmable polarity |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
Results fall due at different cycles:

- **Packet events:** a packet pulse driven for one cycle sets its flag at the rising edge that closes that cycle. The bench drives inputs at falling edges and reads the flag back at the following falling edge.
- **Link changes:** these pass through two synchronizer flops and one edge-detect flop. The bench first checks that the flag is still clear after two rising edges, then checks that it is set after the third.
- **Reads:** read data is combinational in the read cycle, so it is sampled in the middle of the low clock phase before the clearing edge.
- **Clear timing:** the effect of the clear is observed with a second read.
- **Wake pin and interrupt request:** these follow the flags with no further delay. They are checked at the falling edge after a flag changes.

// File: rtl/wake_ctl_pkg.sv
package wake_ctl_pkg;

   localparam int WK_EVT_N   = 3;
   localparam int WK_EN_LSB  = 0;
   localparam int WK_POL_BIT = 3;
   localparam int WK_FLG_LSB = 4;
   localparam int WK_WOL_BIT = 7;
   localparam int WK_REG_W   = 8;

   typedef enum logic [1:0] {
      PS_D0 = 2'b00,
      PS_D1 = 2'b01,
      PS_D2 = 2'b10,
      PS_D3 = 2'b11
   } pwr_state_e;

   typedef struct packed {
      logic                wol;
      logic [WK_EVT_N-1:0] flg;
      logic                pol;
      logic [WK_EVT_N-1:0] en;
   } wake_reg_t;

endpackage

// File: rtl/wake_sync_edge.sv
module wake_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic chg_o
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wake_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign chg_o = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/wake_evt_flag.sv
module wake_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= set_i | (flag_q & ~clr_i);
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/wake_pin_drv.sv
module wake_pin_drv #(
   parameter bit PIN_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_i,
   input  logic pol_i,
   output logic pin_o,
   output logic irq_o
);

   logic pin_d;

   assign pin_d = pol_i ? any_i : ~any_i;

   generate
      if (PIN_REG) begin : g_reg
         logic pin_q;
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pin_q <= 1'b1;
               irq_q <= 1'b0;
            end else begin
               pin_q <= pin_d;
               irq_q <= any_i;
            end
         end
         assign pin_o = pin_q;
         assign irq_o = irq_q;
      end else begin : g_comb
         assign pin_o = pin_d;
         assign irq_o = any_i;
      end
   endgenerate

endmodule

// File: rtl/wake_ctl_reg.sv
module wake_ctl_reg
   import wake_ctl_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter logic [7:0]  REG_ADDR    = 8'h45,
   parameter int          SYNC_STAGES = 2,
   parameter bit          PIN_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wol_default_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic              wpkt_hit_i,
   input  logic              mpkt_hit_i,
   input  logic              link_up_i,
   input  logic              pme_en_i,
   input  logic [1:0]        pwr_state_i,
   output logic              wake_pin_o,
   output logic              irq_o
);

   localparam int EVT_N = WK_EVT_N;

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
         $error("wake_ctl_reg: ADDR_W must be 1..8");
      end
      if ($bits(wake_reg_t) != WK_REG_W) begin : g_bad_layout
         $error("wake_ctl_reg: register layout must be 8 bits");
      end
   endgenerate

   logic             acc_hit;
   logic             wr_hit;
   logic             rd_hit;
   logic [EVT_N-1:0] en_q;
   logic             pol_q;
   logic             wol_q;
   logic             armed;
   logic             link_chg;
   logic [EVT_N-1:0] evt_raw;
   logic [EVT_N-1:0] flag_q;
   wake_reg_t        reg_val;

   assign acc_hit = (addr_i == REG_ADDR[ADDR_W-1:0]);
   assign wr_hit  = wr_en_i & acc_hit;
   assign rd_hit  = rd_en_i & acc_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= 1'b0;
         wol_q <= wol_default_i;
      end else if (wr_hit) begin
         en_q  <= wdata_i[WK_EN_LSB +: EVT_N];
         pol_q <= wdata_i[WK_POL_BIT];
         wol_q <= wdata_i[WK_WOL_BIT];
      end
   end

   assign armed = wol_q | (pme_en_i & (pwr_state_e'(pwr_state_i) != PS_D0));

   wake_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (link_up_i),
      .chg_o   (link_chg)
   );

   assign evt_raw = {link_chg, mpkt_hit_i, wpkt_hit_i};

   generate
      for (genvar i = 0; i < EVT_N; i++) begin : g_flag
         wake_evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_raw[i] & en_q[i] & armed),
            .clr_i  (rd_hit),
            .flag_o (flag_q[i])
         );
      end
   endgenerate

   always_comb begin
      reg_val     = '0;
      reg_val.wol = wol_q;
      reg_val.flg = flag_q;
      reg_val.pol = pol_q;
      reg_val.en  = en_q;
   end

   assign rdata_o = rd_hit ? reg_val : '0;

   wake_pin_drv #(
      .PIN_REG (PIN_REG)
   ) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .any_i (|flag_q),
      .pol_i (pol_q),
      .pin_o (wake_pin_o),
      .irq_o (irq_o)
   );

endmodule

// File: rtl/wake_ctl_reg_chk.sv
module wake_ctl_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] flags,
   input logic [2:0] en,
   input logic       wol,
   input logic       pol,
   input logic       rd_hit,
   input logic [2:0] evt,
   input logic       pme_en,
   input logic [1:0] pwr_state,
   input logic [7:0] rdata,
   input logic       wake_pin,
   input logic       irq
);

   AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(flags[0]) && !$past(en[0])) |-> !flags[0]); // R4

   AST_MAGIC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(flags[1]) && !$past(en[1])) |-> !flags[1]); // R4

   AST_NO_SET_IN_D0: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags == 3'b000) && !wol && (pwr_state == 2'b00)) |=> (flags == 3'b000)); // R5

   AST_NO_SET_NO_PME: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags == 3'b000) && !wol && !pme_en) |=> (flags == 3'b000)); // R5

   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && (evt == 3'b000)) |=> (flags == 3'b000)); // R8

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hit && flags[2]) |=> flags[2]); // R8

   AST_KEEP_COINCIDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && evt[1] && en[1] && wol) |=> flags[1]); // R9

   AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == 3'b000) |-> (wake_pin == !pol && !irq)); // R10

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rdata == 8'h00)); // R11

endmodule

bind wake_ctl_reg wake_ctl_reg_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flags     (flag_q),
   .en        (en_q),
   .wol       (wol_q),
   .pol       (pol_q),
   .rd_hit    (rd_hit),
   .evt       (evt_raw),
   .pme_en    (pme_en_i),
   .pwr_state (pwr_state_i),
   .rdata     (rdata_o),
   .wake_pin  (wake_pin_o),
   .irq       (irq_o)
);

// File: tb/wake_ctl_reg_bench.sv
`timescale 1ns/1ps
module wake_ctl_reg_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wol_default = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       wpkt = 1'b0;
   logic       mpkt = 1'b0;
   logic       link = 1'b0;
   logic       pme = 1'b0;
   logic [1:0] pwr = 2'b00;
   logic       wake_pin;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   wake_ctl_reg u_wake_ctl_reg (
      .clk           (clk),
      .rst_n         (rst_n),
      .wol_default_i (wol_default),
      .addr_i        (addr),
      .wr_en_i       (wr_en),
      .rd_en_i       (rd_en),
      .wdata_i       (wdata),
      .rdata_o       (rdata),
      .wpkt_hit_i    (wpkt),
      .mpkt_hit_i    (mpkt),
      .link_up_i     (link),
      .pme_en_i      (pme),
      .pwr_state_i   (pwr),
      .wake_pin_o    (wake_pin),
      .irq_o         (irq)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic do_reset(input logic wol_def);
      @(negedge clk);
      rst_n = 1'b0;
      wol_default = wol_def;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #5 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) wpkt = 1'b1; else mpkt = 1'b1;
      @(negedge clk);
      wpkt = 1'b0; mpkt = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset(1'b0);
      do_read(8'h45, d);
      chk("R1 reset value wol=0", d, 8'h00);
      chk("R10 idle pin pol low", {7'd0, wake_pin}, 8'h01);
      chk("R11 idle rdata", rdata, 8'h00);
      do_reset(1'b1);
      do_read(8'h45, d);
      chk("R1 reset value wol=1", d, 8'h80);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      do_reset(1'b0);
      do_write(8'h44, 8'hFF);
      do_read(8'h45, d);
      chk("R2 write elsewhere ignored", d, 8'h00);
      do_write(8'h45, 8'hFF);
      do_read(8'h45, d);
      chk("R3 writable bits", d, 8'h8F);
      do_read(8'h46, d);
      chk("R2 read elsewhere zero", d, 8'h00);
      do_write(8'h45, 8'h0A);
      do_read(8'h45, d);
      chk("R3 readback pattern", d, 8'h0A);
   endtask

   task automatic t_gating();
      logic [7:0] d;
      do_reset(1'b0);
      do_write(8'h45, 8'h07);
      pme = 1'b0; pwr = 2'b11;
      pulse(0);
      do_read(8'h45, d);
      chk("R5 no PME enable", d, 8'h07);
      pme = 1'b1; pwr = 2'b00;
      pulse(0);
      do_read(8'h45, d);
      chk("R5 state D0", d, 8'h07);
      pwr = 2'b11;
      pulse(0);
      do_read(8'h45, d);
      chk("R5 armed wake packet", d, 8'h17);
      do_read(8'h45, d);
      chk("R8 cleared after read", d, 8'h07);
      do_write(8'h45, 8'h06);
      pulse(0);
      do_read(8'h45, d);
      chk("R4 disabled wake packet", d, 8'h06);
      pulse(1);
      do_read(8'h45, d);
      chk("R4 magic packet to bit5", d, 8'h26);
      pme = 1'b0; pwr = 2'b00;
   endtask

   task automatic t_wol();
      logic [7:0] d;
      do_reset(1'b1);
      pme = 1'b0; pwr = 2'b00;
      do_write(8'h45, 8'h81);
      pulse(0);
      do_read(8'h45, d);
      chk("R6 override bypasses gating", d, 8'h91);
      do_write(8'h45, 8'h01);
      pulse(0);
      do_read(8'h45, d);
      chk("R6 override cleared", d, 8'h01);
   endtask

   task automatic t_link();
      logic [7:0] d;
      do_reset(1'b0);
      pme = 1'b1; pwr = 2'b10;
      do_write(8'h45, 8'h04);
      @(negedge clk);
      link = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 not yet after two edges", {7'd0, irq}, 8'h00);
      @(negedge clk);
      chk("R7 set after three edges", {7'd0, irq}, 8'h01);
      do_read(8'h45, d);
      chk("R7 connect event", d, 8'h44);
      @(negedge clk);
      link = 1'b0;
      repeat (4) @(negedge clk);
      do_read(8'h45, d);
      chk("R7 disconnect event", d, 8'h44);
      pme = 1'b0; pwr = 2'b00;
   endtask

   task automatic t_coincident();
      logic [7:0] d;
      do_reset(1'b1);
      do_write(8'h45, 8'h87);
      pulse(0);
      @(negedge clk);
      addr = 8'h45; rd_en = 1'b1; mpkt = 1'b1;
      #5 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; mpkt = 1'b0;
      chk("R8 read shows flag", d, 8'h97);
      do_read(8'h45, d);
      chk("R9 coincident event kept", d, 8'hA7);
   endtask

   task automatic t_pin();
      logic [7:0] d;
      do_reset(1'b1);
      do_write(8'h45, 8'h81);
      chk("R10 pol low idle", {6'd0, wake_pin, irq}, 8'h02);
      pulse(0);
      chk("R10 pol low asserted", {6'd0, wake_pin, irq}, 8'h01);
      do_write(8'h45, 8'h89);
      chk("R10 pol high asserted", {6'd0, wake_pin, irq}, 8'h03);
      do_read(8'h45, d);
      chk("R10 pol high idle after clear", {6'd0, wake_pin, irq}, 8'h00);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_gating();
      t_wol();
      t_link();
      t_coincident();
      t_pin();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule